// File: doc/BRIEF.md
# Address Match Trigger Bank

This block holds a small set of hardware breakpoint and watchpoint triggers for a processor core. Every cycle the core presents one access: an instruction fetch, a load or a store. It gives the access address and the privilege level it runs at. Each armed trigger compares that address with its own compare value. The comparison is exact, a naturally aligned power-of-two range, greater-or-equal, or less-than. A trigger counts only for the access kinds and privilege levels it is enabled for. When a trigger fires, the block marks it as hit and points the index register at it, so a handler can find out which trigger fired. In the next cycle it raises either a breakpoint-exception request or a debug-entry request.

Software reaches the block through a plain CSR read/write port with four addressable registers: an index register, a per-trigger control word, a per-trigger compare value, and a trigger-control word that holds a machine-mode enable and a saved copy of that enable. Software learns what the block can do by writing a value and reading it back. The index register saturates at the trigger count. The control word keeps its old mode when software writes a mode the block does not implement.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset the index register reads 0, each control word reads 0x2000_0000 (bits 31:28 hold 2, all other bits are 0), each compare value reads 0, the trigger-control word reads 0, and both request outputs are low.
- R2: Writing a value of NTRIG (4) or more to the index register (csr_addr 0) makes it read back NTRIG. Writing a smaller value makes it read back that value. While the index register holds NTRIG, the control and compare registers read 0 and writes to them change no trigger.
- R3: The control word (csr_addr 1) keeps load at bit 0, store at bit 1, execute at bit 2, U enable at bit 3, S enable at bit 4, M enable at bit 6, mode at bits 10:7, action at bits 15:12, hit at bit 20 and a debug-only flag at bit 27. A written mode above 3 leaves the previous mode in place. A written action above 1 leaves the previous action in place. Bits 31:28 always read 2. Every other bit reads 0.
- R4: Mode 0 fires when the access address equals the compare value (csr_addr 2).
- R5: Mode 1 is a range match. If the compare value ends in k one bits (k ≥ 0), the block ignores the low k+1 address bits and compares the remaining upper bits.
- R6: Mode 2 fires when the address is greater than or equal to the compare value, unsigned. Mode 3 fires when the address is less than the compare value, unsigned.
- R7: The access kind is given by acc_kind: 0 = fetch, 1 = load, 2 = store. A trigger fires only for the kinds whose execute, load or store bit is set.
- R8: acc_priv is 0 for U, 1 for S and 3 for M. A trigger fires only when the enable bit for the current level is set. In M it also needs bit 3 of the trigger-control word (csr_addr 3).
- R9: One cycle after a firing access, the lowest-numbered firing trigger has its hit bit set and the index register holds that trigger's number. brk_exc_o pulses if that trigger's action is 0; dbg_req_o pulses if its action is 1.
- R10: When a breakpoint exception is raised for an access in M, bit 3 of the trigger-control word is copied into bit 7 and bit 3 is then cleared. A trap_ret pulse copies bit 7 back into bit 3. A debug-entry request, or an exception raised outside M, leaves the word unchanged.
- R11: After a control word is written with 0, its trigger fires for no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Write strobe for the CSR port |
| csr_addr | input | 2 | Register code: 0 index, 1 control, 2 compare, 3 trigger control |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for csr_addr, combinational |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store |
| acc_addr | input | 32 | Access address |
| acc_priv | input | 2 | Privilege level: 0 U, 1 S, 3 M |
| trap_ret | input | 1 | Return from trap; restores the M-mode enable |
| brk_exc_o | output | 1 | Breakpoint exception request, one cycle after the access |
| dbg_req_o | output | 1 | Debug-entry request, one cycle after the access |

## Verification
The assertions check these on every cycle: the index register never exceeds the trigger count; a request always coincides with a set hit bit on the trigger the index points at; the enable save and restore around M-mode exceptions and trap_ret; a written unsupported mode leaves the stored mode unchanged; and a zeroed control word produces no match. Only the bench scenarios can show that each compare mode, including range sizes taken from trailing ones and the boundaries of the greater-or-equal and less-than compares, fires on the right addresses. The same holds for kind and privilege qualification, the lowest-index priority among simultaneous hits, and the read-back values software uses to discover what the block supports.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam logic [1:0] REG_INDEX = 2'd0;
  localparam logic [1:0] REG_CTRL  = 2'd1;
  localparam logic [1:0] REG_CMP   = 2'd2;
  localparam logic [1:0] REG_TCTL  = 2'd3;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [3:0] TRIG_KIND_ADDR = 4'd2;

  typedef struct packed {
    logic       dbg_only;
    logic       hit;
    logic       act_dbg;
    logic [1:0] mode;
    logic       en_m;
    logic       en_s;
    logic       en_u;
    logic       on_fetch;
    logic       on_store;
    logic       on_load;
  } slot_cfg_t;
endpackage

// File: rtl/dbg_trig_cmp.sv
module dbg_trig_cmp #(
  parameter int AW = 32
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ref_val,
  output logic          eq_hit
);
  logic [AW-1:0] ignore_mask;

  // trailing ones of ref_val plus the next bit mark the ignored low bits
  always_comb begin
    ignore_mask = ref_val ^ (ref_val + AW'(1));
    unique case (mode)
      2'd0:    eq_hit = (addr == ref_val);
      2'd1:    eq_hit = (((addr ^ ref_val) & ~ignore_mask) == '0);
      2'd2:    eq_hit = (addr >= ref_val);
      default: eq_hit = (addr < ref_val);
    endcase
  end
endmodule

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot
  import dbg_trig_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_cmp,
  input  logic [XLEN-1:0] wdata,
  input  logic            set_hit,
  input  logic            acc_valid,
  input  logic [1:0]      acc_kind,
  input  logic [XLEN-1:0] acc_addr,
  input  logic [1:0]      acc_priv,
  input  logic            m_allow,
  output logic [XLEN-1:0] ctrl_rd,
  output logic [XLEN-1:0] cmp_rd,
  output logic            match_o,
  output logic            act_dbg_o,
  output logic            hit_o
);
  slot_cfg_t       cfg_q, cfg_n;
  logic            cfg_en;
  logic [XLEN-1:0] cmp_q;
  logic            addr_hit, kind_ok, priv_ok;
  logic            unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    cfg_n  = cfg_q;
    cfg_en = wr_ctrl | set_hit;
    if (wr_ctrl) begin
      cfg_n.on_load  = wdata[0];
      cfg_n.on_store = wdata[1];
      cfg_n.on_fetch = wdata[2];
      cfg_n.en_u     = wdata[3];
      cfg_n.en_s     = wdata[4];
      cfg_n.en_m     = wdata[6];
      if (wdata[10:7] <= 4'd3) cfg_n.mode = wdata[8:7];
      if (wdata[15:12] <= 4'd1) cfg_n.act_dbg = wdata[12];
      cfg_n.hit      = wdata[20];
      cfg_n.dbg_only = wdata[27];
    end
    if (set_hit) cfg_n.hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (wr_cmp) cmp_q <= wdata;
  end

  dbg_trig_cmp #(.AW(XLEN)) u_cmp (
    .mode    (cfg_q.mode),
    .addr    (acc_addr),
    .ref_val (cmp_q),
    .eq_hit  (addr_hit)
  );

  always_comb begin
    kind_ok = (acc_kind == KIND_FETCH && cfg_q.on_fetch) ||
              (acc_kind == KIND_LOAD  && cfg_q.on_load)  ||
              (acc_kind == KIND_STORE && cfg_q.on_store);
    unique case (acc_priv)
      PRIV_U:  priv_ok = cfg_q.en_u;
      PRIV_S:  priv_ok = cfg_q.en_s;
      PRIV_M:  priv_ok = cfg_q.en_m & m_allow;
      default: priv_ok = 1'b0;
    endcase
  end

  assign match_o   = acc_valid & kind_ok & priv_ok & addr_hit;
  assign act_dbg_o = cfg_q.act_dbg;
  assign hit_o     = cfg_q.hit;
  assign cmp_rd    = cmp_q;
  assign ctrl_rd   = XLEN'({TRIG_KIND_ADDR, cfg_q.dbg_only, 6'd0, cfg_q.hit,
                            4'd0, 3'd0, cfg_q.act_dbg, 1'b0, 2'd0, cfg_q.mode,
                            cfg_q.en_m, 1'b0, cfg_q.en_s, cfg_q.en_u,
                            cfg_q.on_fetch, cfg_q.on_store, cfg_q.on_load});

  // R3: an unsupported mode write leaves the stored mode alone
  p_keep_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[10:7] > 4'd3) |=> (cfg_q.mode == $past(cfg_q.mode)));

  // R11: a zeroed control word matches nothing
  p_zero_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !set_hit && wdata == '0) |=> !match_o);
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int NTRIG = 4,
  parameter int XLEN  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_wr,
  input  logic [1:0]      csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            acc_valid,
  input  logic [1:0]      acc_kind,
  input  logic [XLEN-1:0] acc_addr,
  input  logic [1:0]      acc_priv,
  input  logic            trap_ret,
  output logic            brk_exc_o,
  output logic            dbg_req_o
);
  localparam int IW = $clog2(NTRIG + 1);
  localparam logic [IW-1:0] SEL_NONE = IW'(NTRIG);

  logic [IW-1:0]   sel_q, sel_n;
  logic            sel_en;
  logic            mte_q, mpte_q, mte_n, mpte_n, tctl_en;
  logic            brk_q, dbg_q;
  logic [NTRIG-1:0] match_vec, act_vec, hit_vec;
  logic [XLEN-1:0] ctrl_rd [NTRIG];
  logic [XLEN-1:0] cmp_rd  [NTRIG];
  logic            win_any, win_dbg;
  logic [IW-1:0]   win_idx;
  logic            exc_from_m;
  logic [NTRIG:0]  hit_ext;

  for (genvar i = 0; i < NTRIG; i++) begin : g_slot
    dbg_trig_slot #(.XLEN(XLEN)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (csr_wr && csr_addr == REG_CTRL && sel_q == IW'(i)),
      .wr_cmp    (csr_wr && csr_addr == REG_CMP  && sel_q == IW'(i)),
      .wdata     (csr_wdata),
      .set_hit   (win_any && win_idx == IW'(i)),
      .acc_valid (acc_valid),
      .acc_kind  (acc_kind),
      .acc_addr  (acc_addr),
      .acc_priv  (acc_priv),
      .m_allow   (mte_q),
      .ctrl_rd   (ctrl_rd[i]),
      .cmp_rd    (cmp_rd[i]),
      .match_o   (match_vec[i]),
      .act_dbg_o (act_vec[i]),
      .hit_o     (hit_vec[i])
    );
  end

  // lowest index wins
  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    win_dbg = 1'b0;
    for (int i = NTRIG - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        win_any = 1'b1;
        win_idx = IW'(i);
        win_dbg = act_vec[i];
      end
    end
  end

  assign exc_from_m = win_any && !win_dbg && acc_priv == PRIV_M;

  always_comb begin
    sel_n  = sel_q;
    sel_en = 1'b0;
    if (win_any) begin
      sel_n  = win_idx;
      sel_en = 1'b1;
    end else if (csr_wr && csr_addr == REG_INDEX) begin
      sel_n  = (csr_wdata >= XLEN'(NTRIG)) ? SEL_NONE : IW'(csr_wdata);
      sel_en = 1'b1;
    end
  end

  always_comb begin
    mte_n   = mte_q;
    mpte_n  = mpte_q;
    tctl_en = 1'b1;
    if (exc_from_m) begin
      mpte_n = mte_q;
      mte_n  = 1'b0;
    end else if (trap_ret) begin
      mte_n  = mpte_q;
    end else if (csr_wr && csr_addr == REG_TCTL) begin
      mte_n  = csr_wdata[3];
      mpte_n = csr_wdata[7];
    end else begin
      tctl_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mte_q  <= 1'b0;
      mpte_q <= 1'b0;
    end else if (tctl_en) begin
      mte_q  <= mte_n;
      mpte_q <= mpte_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
      dbg_q <= 1'b0;
    end else begin
      brk_q <= win_any & ~win_dbg;
      dbg_q <= win_any &  win_dbg;
    end
  end

  always_comb begin
    csr_rdata = '0;
    unique case (csr_addr)
      REG_INDEX: csr_rdata = XLEN'(sel_q);
      REG_CTRL:  for (int i = 0; i < NTRIG; i++)
                   if (sel_q == IW'(i)) csr_rdata = ctrl_rd[i];
      REG_CMP:   for (int i = 0; i < NTRIG; i++)
                   if (sel_q == IW'(i)) csr_rdata = cmp_rd[i];
      default:   csr_rdata = XLEN'({mpte_q, 3'd0, mte_q, 3'd0});
    endcase
  end

  assign brk_exc_o = brk_q;
  assign dbg_req_o = dbg_q;
  assign hit_ext   = {1'b0, hit_vec};

  p_sel_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= SEL_NONE);

  // R9: a request points at a trigger whose hit flag is set
  p_req_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_exc_o || dbg_req_o) |-> (sel_q < SEL_NONE && hit_ext[sel_q]));

  p_m_save_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_from_m |=> (!mte_q && mpte_q == $past(mte_q)));

  p_ret_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ret && !exc_from_m) |=> (mte_q == $past(mpte_q)));
endmodule

// File: tb/dbg_trig_unit_test.sv
module dbg_trig_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [1:0]  csr_addr = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = 2'd0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_priv = 2'd0;
  logic        trap_ret = 1'b0;
  logic        brk_exc_o, dbg_req_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  brk;
    logic  dbg;
    string req;
  } exp_t;
  exp_t sb[$];
  logic acc_seen = 1'b0;

  always #10 clk = ~clk;

  dbg_trig_unit uut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .acc_valid(acc_valid),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_priv(acc_priv),
    .trap_ret(trap_ret), .brk_exc_o(brk_exc_o), .dbg_req_o(dbg_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares request outputs one cycle after each access
  always @(posedge clk) acc_seen <= acc_valid;
  always @(negedge clk) begin
    if (acc_seen && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.req, {30'd0, brk_exc_o, dbg_req_o}, {30'd0, e.brk, e.dbg});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    csr_addr = a;
    #1;
    chk(req, csr_rdata, exp);
  endtask

  task automatic acc(input logic [1:0] kind, input logic [31:0] addr,
                     input logic [1:0] priv, input logic eb, input logic ed,
                     input string req);
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = kind; acc_addr = addr; acc_priv = priv;
    e.brk = eb; e.dbg = ed; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic slot(input int idx, input logic [31:0] c1, input logic [31:0] c2);
    wr(2'd0, idx);
    wr(2'd2, c2);
    wr(2'd1, c1);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, 32'h0, "R1 index");
    rd(2'd1, 32'h2000_0000, "R1 ctrl");
    rd(2'd2, 32'h0, "R1 cmp");
    rd(2'd3, 32'h0, "R1 tctl");
    chk("R1 requests", {30'd0, brk_exc_o, dbg_req_o}, 32'h0);

    // R2 index saturation
    wr(2'd0, 32'd9);
    rd(2'd0, 32'd4, "R2 saturate");
    rd(2'd1, 32'h0, "R2 none ctrl");
    wr(2'd1, 32'h0000_000F);
    wr(2'd2, 32'h1234_5678);
    wr(2'd0, 32'd0);
    rd(2'd1, 32'h2000_0000, "R2 write ignored ctrl");
    rd(2'd2, 32'h0, "R2 write ignored cmp");
    wr(2'd0, 32'd2);
    rd(2'd0, 32'd2, "R2 in range");

    // R3 legalization
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h0000_0141);
    rd(2'd1, 32'h2000_0141, "R3 plain");
    wr(2'd1, 32'hF000_5B84);
    rd(2'd1, 32'h2000_0104, "R3 mode kept");

    // R4 exact
    slot(0, 32'h0000_000C, 32'h0000_1000);
    acc(2'd0, 32'h0000_1001, 2'd0, 1'b0, 1'b0, "R4 miss");
    acc(2'd0, 32'h0000_1000, 2'd0, 1'b1, 1'b0, "R4 hit");
    rd(2'd1, 32'h2010_000C, "R4 hit flag");

    // R5 range
    slot(0, 32'h0000_0089, 32'h2000_0007);
    acc(2'd1, 32'h2000_000F, 2'd0, 1'b1, 1'b0, "R5 16B top");
    acc(2'd1, 32'h2000_0010, 2'd0, 1'b0, 1'b0, "R5 16B above");
    acc(2'd1, 32'h2000_0000, 2'd0, 1'b1, 1'b0, "R5 16B base");
    wr(2'd2, 32'h2000_0000);
    acc(2'd1, 32'h2000_0001, 2'd0, 1'b1, 1'b0, "R5 2B odd");
    acc(2'd1, 32'h2000_0002, 2'd0, 1'b0, 1'b0, "R5 2B next");

    // R6 ordered compares
    slot(0, 32'h0000_010A, 32'h0000_8000);
    acc(2'd2, 32'h0000_8000, 2'd0, 1'b1, 1'b0, "R6 ge equal");
    acc(2'd2, 32'h0000_7FFF, 2'd0, 1'b0, 1'b0, "R6 ge below");
    wr(2'd1, 32'h0000_018A);
    acc(2'd2, 32'h0000_7FFF, 2'd0, 1'b1, 1'b0, "R6 lt below");
    acc(2'd2, 32'h0000_8000, 2'd0, 1'b0, 1'b0, "R6 lt equal");

    // R7 access kinds
    slot(0, 32'h0000_0009, 32'h0000_0040);
    acc(2'd0, 32'h0000_0040, 2'd0, 1'b0, 1'b0, "R7 fetch");
    acc(2'd2, 32'h0000_0040, 2'd0, 1'b0, 1'b0, "R7 store");
    acc(2'd1, 32'h0000_0040, 2'd0, 1'b1, 1'b0, "R7 load");

    // R8 privilege, R10 enable save and restore
    slot(0, 32'h0000_0014, 32'h0000_0050);
    acc(2'd0, 32'h0000_0050, 2'd0, 1'b0, 1'b0, "R8 U off");
    acc(2'd0, 32'h0000_0050, 2'd1, 1'b1, 1'b0, "R8 S on");
    wr(2'd1, 32'h0000_0044);
    acc(2'd0, 32'h0000_0050, 2'd3, 1'b0, 1'b0, "R8 M gated");
    wr(2'd3, 32'h0000_0008);
    acc(2'd0, 32'h0000_0050, 2'd3, 1'b1, 1'b0, "R8 M on");
    rd(2'd3, 32'h0000_0080, "R10 saved");
    acc(2'd0, 32'h0000_0050, 2'd3, 1'b0, 1'b0, "R10 no refire");
    @(negedge clk); trap_ret = 1'b1;
    @(negedge clk); trap_ret = 1'b0;
    rd(2'd3, 32'h0000_0088, "R10 restored");

    // R9 debug action and priority
    slot(3, 32'h0000_100C, 32'h0000_0300);
    wr(2'd0, 32'd0);
    acc(2'd0, 32'h0000_0300, 2'd0, 1'b0, 1'b1, "R9 debug req");
    rd(2'd0, 32'd3, "R9 index");
    rd(2'd1, 32'h2010_100C, "R9 hit flag");
    slot(1, 32'h0000_000C, 32'h0000_0400);
    slot(2, 32'h0000_000C, 32'h0000_0400);
    acc(2'd0, 32'h0000_0400, 2'd0, 1'b1, 1'b0, "R9 two hit");
    rd(2'd0, 32'd1, "R9 lowest wins");
    rd(2'd3, 32'h0000_0088, "R10 U exc keeps");

    // R11 zero disables
    wr(2'd0, 32'd1);
    wr(2'd1, 32'h0);
    rd(2'd1, 32'h2000_0000, "R11 cleared");
    acc(2'd0, 32'h0000_0400, 2'd0, 1'b1, 1'b0, "R11 next slot");
    rd(2'd0, 32'd2, "R11 index");
    wr(2'd1, 32'h0);
    acc(2'd0, 32'h0000_0400, 2'd0, 1'b0, 1'b0, "R11 all off");

    repeat (2) @(negedge clk);
    if (sb.size() != 0) chk("scoreboard drained", sb.size(), 32'd0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule